// File: doc/BRIEF.md
# Reserved-Address Identification and Sleep Handler

This block sits beside the byte engine of a two-wire (I2C) target. It handles the command sequences that use reserved bus addresses. The byte engine reports bus events to it, one per cycle, as pulses: a START, a STOP, a received byte, or the master's acknowledge bit after a byte the target sent. The handler answers received bytes with an acknowledge decision. During a readout it supplies the next byte to transmit. It also reports the target's power state, and the surrounding logic uses that state to block normal memory traffic while the target is not ready.

Every sequence opens with a START and the select code `0xF8`. The next byte is the target's own address, compared on bits 7:2 only, so bits 1:0 may hold anything. A repeated START and a command code follow. The command is one of three:
- `0xF9` reads three identification bytes.
- `0xCD` reads an eight-byte serial number.
- `0x86` arms a sleep request, and the next STOP carries it out.

When a sleeping target sees its own address, it NACKs that byte and starts a wake-up timer. It keeps answering NACK until a fixed number of clock cycles has passed.

Top module: `rsv_id_sleep`

## Requirements
- R1: After reset the handler is awake (`ready_o`=1, `asleep_o`=0), gives no response and has no readout active.
- R2: A `0xF8` byte as the first byte after START, while awake, gets an ACK (`resp_valid_o`=1, `resp_ack_o`=1 in the cycle after the byte event).
- R3: The byte after `0xF8` is acknowledged when its bits 7:2 equal `own_id_i`, whatever its bits 1:0 hold.
- R4: If that byte does not match, the handler gives no response to any byte until the next STOP, even across a repeated START followed by a command code.
- R5: After a repeated START, command `0xF9` is acknowledged and starts a readout of the 24-bit value {manufacturer[11:0], product[8:0], revision[2:0]}, most significant byte first. Each master ACK advances to the next byte. The default bytes are 0x00, 0x44, 0x00.
- R6: After a repeated START, command `0xCD` is acknowledged and starts a readout of `serial_num_i` as eight bytes, bits 63:56 first.
- R7: A master ACK after the last identification byte or serial byte makes the handler present `0xFF` for every further byte.
- R8: A master NACK ends the readout (`tx_active_o`=0), and bytes that follow before a new START get no response.
- R9: Command `0x86` after a repeated START is acknowledged. The next STOP enters sleep (`asleep_o`=1, `ready_o`=0).
- R10: If the sequence is broken before the command (a STOP, or a byte where the repeated START belongs), the handler returns to idle without sleeping. A later byte other than `0xF8` right after START gets no response.
- R11: While asleep, a byte after START whose bits 7:2 equal `own_id_i` gets a NACK and starts wake-up (`asleep_o`=0, `ready_o`=0). A non-matching byte gets no response and the handler stays asleep.
- R12: `ready_o` rises exactly `WAKE_CYCLES` clock cycles after the wake-starting byte is taken. Until then, every matching address byte gets a NACK.
- R13: An unknown command code after the repeated START gets no response and starts no readout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| own_id_i | input | 6 | Own address, compared with bits 7:2 of address bytes |
| serial_num_i | input | 64 | Serial number value (customer id, unique number, CRC) |
| ev_start_i | input | 1 | START or repeated START seen (pulse) |
| ev_stop_i | input | 1 | STOP seen (pulse) |
| ev_byte_i | input | 1 | Byte received from the master (pulse) |
| rx_byte_i | input | 8 | Received byte, valid with `ev_byte_i` |
| ev_mack_i | input | 1 | Master acknowledge slot after a transmitted byte (pulse) |
| mack_nack_i | input | 1 | 1 when the master sent NACK in that slot |
| resp_valid_o | output | 1 | Handler claims the response to the previous received byte |
| resp_ack_o | output | 1 | 1 = ACK, 0 = NACK, valid with `resp_valid_o` |
| tx_active_o | output | 1 | A readout is in progress |
| tx_byte_o | output | 8 | Byte to transmit next (0xFF when no readout is active) |
| asleep_o | output | 1 | Target is in sleep |
| ready_o | output | 1 | Target is awake and ready for normal traffic |

## Verification
The bench targets the edges of each readout. After the last identification or serial byte, a design with a wrapping or unchecked index would replay byte 0 or output stale data where `0xFF` is expected. After a master NACK, a design that left the read state would keep claiming later bytes. The failed-select case runs on through a repeated START and a valid-looking `0xF9`; a handler that forgot the mismatch would acknowledge it. A broken sequence followed by a STOP checks that sleep is taken only after the `0x86` command. The wake window is measured to the exact cycle, with a second matching address sent in the middle: a timer off by one, or one that restarts on the second address, moves the rise of `ready_o`.

// File: rtl/rsv_id_pkg.sv
package rsv_id_pkg;

  localparam logic [7:0] CODE_SELECT = 8'hF8;
  localparam logic [7:0] CODE_DEVID  = 8'hF9;
  localparam logic [7:0] CODE_SERIAL = 8'hCD;
  localparam logic [7:0] CODE_SLEEP  = 8'h86;

  localparam int IDX_W     = 4;
  localparam int ID_BYTES  = 3;
  localparam int SN_BYTES  = 8;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_FRAME,
    SQ_SELECT,
    SQ_MUTE,
    SQ_ARMED,
    SQ_CMD,
    SQ_READ,
    SQ_SLEEPCMD
  } seq_t;

  typedef enum logic [1:0] {
    PW_AWAKE,
    PW_ASLEEP,
    PW_WAKING
  } pwr_t;

  typedef enum logic {
    SRC_DEVID,
    SRC_SERIAL
  } src_t;

endpackage

// File: rtl/rsv_wake_timer.sv
module rsv_wake_timer
  import rsv_id_pkg::*;
#(
  parameter int WAKE_CYCLES = 4000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req_i,
  input  logic wake_req_i,
  output logic asleep_o,
  output logic ready_o
);

  localparam int CW = $clog2(WAKE_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(WAKE_CYCLES);

  pwr_t          pwr_q, pwr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          pwr_en, cnt_en;

  always_comb begin
    pwr_d = pwr_q;
    cnt_d = cnt_q;
    unique case (pwr_q)
      PW_AWAKE: begin
        if (sleep_req_i) pwr_d = PW_ASLEEP;
      end
      PW_ASLEEP: begin
        if (wake_req_i) begin
          pwr_d = PW_WAKING;
          cnt_d = LOAD;
        end
      end
      PW_WAKING: begin
        if (cnt_q <= CW'(1)) begin
          pwr_d = PW_AWAKE;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q - CW'(1);
        end
      end
      default: pwr_d = PW_AWAKE;
    endcase
  end

  assign pwr_en = (pwr_d != pwr_q);
  assign cnt_en = (pwr_q == PW_WAKING) || (pwr_d == PW_WAKING);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_q <= PW_AWAKE;
      cnt_q <= '0;
    end else begin
      if (pwr_en) pwr_q <= pwr_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign asleep_o = (pwr_q == PW_ASLEEP);
  assign ready_o  = (pwr_q == PW_AWAKE);

endmodule

// File: rtl/rsv_tx_select.sv
module rsv_tx_select
  import rsv_id_pkg::*;
#(
  parameter logic [11:0] MFR_ID  = 12'h004,
  parameter logic [8:0]  PROD_ID = 9'h080,
  parameter logic [2:0]  DIE_REV = 3'h0
) (
  input  logic [63:0]      serial_num_i,
  input  src_t             src_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [7:0]       byte_o
);

  localparam logic [8*ID_BYTES-1:0] ID_WORD = {MFR_ID, PROD_ID, DIE_REV};

  always_comb begin
    byte_o = 8'hFF;
    if (src_i == SRC_DEVID) begin
      for (int k = 0; k < ID_BYTES; k++) begin
        if (idx_i == IDX_W'(k)) byte_o = ID_WORD[8*(ID_BYTES-1-k) +: 8];
      end
    end else begin
      for (int k = 0; k < SN_BYTES; k++) begin
        if (idx_i == IDX_W'(k)) byte_o = serial_num_i[8*(SN_BYTES-1-k) +: 8];
      end
    end
  end

endmodule

// File: rtl/rsv_seq_fsm.sv
module rsv_seq_fsm
  import rsv_id_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [5:0]       own_id_i,
  input  logic             awake_i,
  input  logic             ev_start_i,
  input  logic             ev_stop_i,
  input  logic             ev_byte_i,
  input  logic [7:0]       rx_byte_i,
  input  logic             ev_mack_i,
  input  logic             mack_nack_i,
  output logic             resp_valid_o,
  output logic             resp_ack_o,
  output logic             tx_active_o,
  output src_t             src_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             sleep_req_o,
  output logic             wake_req_o
);

  seq_t             seq_q, seq_d;
  src_t             src_q, src_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             rv_q, rv_d, ra_q, ra_d;
  logic             addr_hit;
  logic             rd_en;

  assign addr_hit = (rx_byte_i[7:2] == own_id_i);

  always_comb begin
    seq_d       = seq_q;
    src_d       = src_q;
    idx_d       = idx_q;
    rv_d        = 1'b0;
    ra_d        = 1'b0;
    sleep_req_o = 1'b0;
    wake_req_o  = 1'b0;
    if (ev_start_i) begin
      if (seq_q == SQ_MUTE)                   seq_d = SQ_MUTE;
      else if (seq_q == SQ_ARMED && awake_i)  seq_d = SQ_CMD;
      else                                    seq_d = SQ_FRAME;
    end else if (ev_stop_i) begin
      if (seq_q == SQ_SLEEPCMD && awake_i) sleep_req_o = 1'b1;
      seq_d = SQ_IDLE;
    end else if (ev_byte_i) begin
      unique case (seq_q)
        SQ_FRAME: begin
          seq_d = SQ_IDLE;
          if (!awake_i) begin
            if (addr_hit) begin
              rv_d       = 1'b1;
              wake_req_o = 1'b1;
            end
          end else if (rx_byte_i == CODE_SELECT) begin
            rv_d  = 1'b1;
            ra_d  = 1'b1;
            seq_d = SQ_SELECT;
          end
        end
        SQ_SELECT: begin
          if (addr_hit) begin
            rv_d  = 1'b1;
            ra_d  = 1'b1;
            seq_d = SQ_ARMED;
          end else begin
            seq_d = SQ_MUTE;
          end
        end
        SQ_CMD: begin
          seq_d = SQ_IDLE;
          if (rx_byte_i == CODE_DEVID || rx_byte_i == CODE_SERIAL) begin
            rv_d  = 1'b1;
            ra_d  = 1'b1;
            seq_d = SQ_READ;
            idx_d = '0;
            src_d = (rx_byte_i == CODE_DEVID) ? SRC_DEVID : SRC_SERIAL;
          end else if (rx_byte_i == CODE_SLEEP) begin
            rv_d  = 1'b1;
            ra_d  = 1'b1;
            seq_d = SQ_SLEEPCMD;
          end
        end
        SQ_MUTE: seq_d = SQ_MUTE;
        default: seq_d = SQ_IDLE;
      endcase
    end else if (ev_mack_i && seq_q == SQ_READ) begin
      if (mack_nack_i)        seq_d = SQ_IDLE;
      else if (idx_q != '1)   idx_d = idx_q + 1'b1;
    end
  end

  assign rd_en = (idx_d != idx_q) || (src_d != src_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q <= SQ_IDLE;
      src_q <= SRC_DEVID;
      idx_q <= '0;
      rv_q  <= 1'b0;
      ra_q  <= 1'b0;
    end else begin
      seq_q <= seq_d;
      rv_q  <= rv_d;
      ra_q  <= ra_d;
      if (rd_en) begin
        src_q <= src_d;
        idx_q <= idx_d;
      end
    end
  end

  assign resp_valid_o = rv_q;
  assign resp_ack_o   = ra_q;
  assign tx_active_o  = (seq_q == SQ_READ);
  assign src_o        = src_q;
  assign idx_o        = idx_q;

endmodule

// File: rtl/rsv_id_sleep.sv
module rsv_id_sleep
  import rsv_id_pkg::*;
#(
  parameter int          WAKE_CYCLES = 4000,
  parameter logic [11:0] MFR_ID      = 12'h004,
  parameter logic [8:0]  PROD_ID     = 9'h080,
  parameter logic [2:0]  DIE_REV     = 3'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [5:0]  own_id_i,
  input  logic [63:0] serial_num_i,
  input  logic        ev_start_i,
  input  logic        ev_stop_i,
  input  logic        ev_byte_i,
  input  logic [7:0]  rx_byte_i,
  input  logic        ev_mack_i,
  input  logic        mack_nack_i,
  output logic        resp_valid_o,
  output logic        resp_ack_o,
  output logic        tx_active_o,
  output logic [7:0]  tx_byte_o,
  output logic        asleep_o,
  output logic        ready_o
);

  src_t             src;
  logic [IDX_W-1:0] idx;
  logic             sleep_req, wake_req;
  logic [7:0]       sel_byte;

  rsv_seq_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .own_id_i     (own_id_i),
    .awake_i      (ready_o),
    .ev_start_i   (ev_start_i),
    .ev_stop_i    (ev_stop_i),
    .ev_byte_i    (ev_byte_i),
    .rx_byte_i    (rx_byte_i),
    .ev_mack_i    (ev_mack_i),
    .mack_nack_i  (mack_nack_i),
    .resp_valid_o (resp_valid_o),
    .resp_ack_o   (resp_ack_o),
    .tx_active_o  (tx_active_o),
    .src_o        (src),
    .idx_o        (idx),
    .sleep_req_o  (sleep_req),
    .wake_req_o   (wake_req)
  );

  rsv_tx_select #(
    .MFR_ID  (MFR_ID),
    .PROD_ID (PROD_ID),
    .DIE_REV (DIE_REV)
  ) u_txsel (
    .serial_num_i (serial_num_i),
    .src_i        (src),
    .idx_i        (idx),
    .byte_o       (sel_byte)
  );

  rsv_wake_timer #(
    .WAKE_CYCLES (WAKE_CYCLES)
  ) u_wake (
    .clk         (clk),
    .rst_n       (rst_n),
    .sleep_req_i (sleep_req),
    .wake_req_i  (wake_req),
    .asleep_o    (asleep_o),
    .ready_o     (ready_o)
  );

  assign tx_byte_o = tx_active_o ? sel_byte : 8'hFF;

endmodule

module rsv_id_sleep_chk #(
  parameter int WAKE_CYCLES = 4000
) (
  input logic       clk,
  input logic       rst_n,
  input logic [5:0] own_id_i,
  input logic       ev_start_i,
  input logic       ev_stop_i,
  input logic       ev_byte_i,
  input logic [7:0] rx_byte_i,
  input logic       ev_mack_i,
  input logic       mack_nack_i,
  input logic       resp_valid_o,
  input logic       resp_ack_o,
  input logic       tx_active_o,
  input logic       asleep_o,
  input logic       ready_o
);

  int unsigned wake_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     wake_cnt <= 0;
    else if (asleep_o || ready_o)   wake_cnt <= 0;
    else                            wake_cnt <= wake_cnt + 1;
  end

  assert_resp_after_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid_o |-> $past(ev_byte_i));

  assert_read_starts_acked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_active_o) |-> (resp_valid_o && resp_ack_o));

  assert_read_ends_on_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_active_o) |-> $past((ev_mack_i && mack_nack_i) || ev_start_i || ev_stop_i || ev_byte_i));

  assert_sleep_on_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep_o) |-> $past(ev_stop_i));

  assert_wake_on_own_addr_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(asleep_o) |-> ($past(ev_byte_i) && $past(rx_byte_i[7:2] == own_id_i)
                         && resp_valid_o && !resp_ack_o));

  assert_nack_while_not_ready_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid_o && !ready_o) |-> !resp_ack_o);

  assert_wake_window_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> (wake_cnt == WAKE_CYCLES));

endmodule

bind rsv_id_sleep rsv_id_sleep_chk #(.WAKE_CYCLES(WAKE_CYCLES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .own_id_i     (own_id_i),
  .ev_start_i   (ev_start_i),
  .ev_stop_i    (ev_stop_i),
  .ev_byte_i    (ev_byte_i),
  .rx_byte_i    (rx_byte_i),
  .ev_mack_i    (ev_mack_i),
  .mack_nack_i  (mack_nack_i),
  .resp_valid_o (resp_valid_o),
  .resp_ack_o   (resp_ack_o),
  .tx_active_o  (tx_active_o),
  .asleep_o     (asleep_o),
  .ready_o      (ready_o)
);

// File: tb/rsv_id_sleep_bench.sv
module rsv_id_sleep_bench;

  localparam int WAKE = 12;
  localparam logic T = 1'b1;
  localparam logic F = 1'b0;

  typedef enum logic [2:0] {OP_START, OP_STOP, OP_BYTE, OP_ACK, OP_NACK} op_e;

  typedef struct packed {
    op_e        op;
    logic [7:0] data;
    logic       rv;
    logic       ra;
    logic       act;
    logic       chk_tx;
    logic [7:0] tx;
    logic       slp;
    logic       rdy;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 72;
  localparam vec_t VECS [NV] = '{
    // device ID readout: R2, R3, R5, R7, R8
    '{OP_START, 8'h00, F, F, F, F, 8'h00, F, T, 4'd2},
    '{OP_BYTE,  8'hF8, T, T, F, F, 8'h00, F, T, 4'd2},   // R2
    '{OP_BYTE,  8'hA3, T, T, F, F, 8'h00, F, T, 4'd3},   // R3 low bits ignored
    '{OP_START, 8'h00, F, F, F, F, 8'h00, F, T, 4'd5},
    '{OP_BYTE,  8'hF9, T, T, T, T, 8'h00, F, T, 4'd5},   // R5
    '{OP_ACK,   8'h00, F, F, T, T, 8'h44, F, T, 4'd5},
    '{OP_ACK,   8'h00, F, F, T, T, 8'h00, F, T, 4'd5},
    '{OP_ACK,   8'h00, F, F, T, T, 8'hFF, F, T, 4'd7},   // R7
    '{OP_ACK,   8'h00, F, F, T, T, 8'hFF, F, T, 4'd7},
    '{OP_NACK,  8'h00, F, F, F, T, 8'hFF, F, T, 4'd8},   // R8
    '{OP_BYTE,  8'hF8, F, F, F, F, 8'h00, F, T, 4'd8},
    '{OP_STOP,  8'h00, F, F, F, F, 8'h00, F, T, 4'd8},
    // serial readout: R6, R7
    '{OP_START, 8'h00, F, F, F, F, 8'h00, F, T, 4'd6},
    '{OP_BYTE,  8'hF8, T, T, F, F, 8'h00, F, T, 4'd2},
    '{OP_BYTE,  8'hA0, T, T, F, F, 8'h00, F, T, 4'd3},
    '{OP_START, 8'h00, F, F, F, F, 8'h00, F, T, 4'd6},
    '{OP_BYTE,  8'hCD, T, T, T, T, 8'h00, F, T, 4'd6},   // R6
    '{OP_ACK,   8'h00, F, F, T, T, 8'h00, F, T, 4'd6},
    '{OP_ACK,   8'h00, F, F, T, T, 8'hA1, F, T, 4'd6},
    '{OP_ACK,   8'h00, F, F, T, T, 8'hB2, F, T, 4'd6},
    '{OP_ACK,   8'h00, F, F, T, T, 8'hC3, F, T, 4'd6},
    '{OP_ACK,   8'h00, F, F, T, T, 8'hD4, F, T, 4'd6},
    '{OP_ACK,   8'h00, F, F, T, T, 8'hE5, F, T, 4'd6},
    '{OP_ACK,   8'h00, F, F, T, T, 8'h7E, F, T, 4'd6},
    '{OP_ACK,   8'h00, F, F, T, T, 8'hFF, F, T, 4'd7},   // R7
    '{OP_NACK,  8'h00, F, F, F, F, 8'h00, F, T, 4'd8},
    '{OP_STOP,  8'h00, F, F, F, F, 8'h00, F, T, 4'd8},
    // failed select: R4
    '{OP_START, 8'h00, F, F, F, F, 8'h00, F, T, 4'd4},
    '{OP_BYTE,  8'hF8, T, T, F, F, 8'h00, F, T, 4'd4},
    '{OP_BYTE,  8'hA4, F, F, F, F, 8'h00, F, T, 4'd4},   // R4
    '{OP_START, 8'h00, F, F, F, F, 8'h00, F, T, 4'd4},
    '{OP_BYTE,  8'hF9, F, F, F, F, 8'h00, F, T, 4'd4},
    '{OP_STOP,  8'h00, F, F, F, F, 8'h00, F, T, 4'd4},
    '{OP_START, 8'h00, F, F, F, F, 8'h00, F, T, 4'd4},
    '{OP_BYTE,  8'hF8, T, T, F, F, 8'h00, F, T, 4'd4},
    '{OP_STOP,  8'h00, F, F, F, F, 8'h00, F, T, 4'd4},
    // broken sequences: R10
    '{OP_START, 8'h00, F, F, F, F, 8'h00, F, T, 4'd10},
    '{OP_BYTE,  8'hF8, T, T, F, F, 8'h00, F, T, 4'd10},
    '{OP_BYTE,  8'hA0, T, T, F, F, 8'h00, F, T, 4'd10},
    '{OP_STOP,  8'h00, F, F, F, F, 8'h00, F, T, 4'd10},
    '{OP_START, 8'h00, F, F, F, F, 8'h00, F, T, 4'd10},
    '{OP_BYTE,  8'hF9, F, F, F, F, 8'h00, F, T, 4'd10},  // R10
    '{OP_STOP,  8'h00, F, F, F, F, 8'h00, F, T, 4'd10},
    '{OP_START, 8'h00, F, F, F, F, 8'h00, F, T, 4'd10},
    '{OP_BYTE,  8'hF8, T, T, F, F, 8'h00, F, T, 4'd10},
    '{OP_BYTE,  8'hA0, T, T, F, F, 8'h00, F, T, 4'd10},
    '{OP_BYTE,  8'h86, F, F, F, F, 8'h00, F, T, 4'd10},  // R10 no repeated START
    '{OP_STOP,  8'h00, F, F, F, F, 8'h00, F, T, 4'd10},
    // unknown command: R13
    '{OP_START, 8'h00, F, F, F, F, 8'h00, F, T, 4'd13},
    '{OP_BYTE,  8'hF8, T, T, F, F, 8'h00, F, T, 4'd13},
    '{OP_BYTE,  8'hA1, T, T, F, F, 8'h00, F, T, 4'd13},
    '{OP_START, 8'h00, F, F, F, F, 8'h00, F, T, 4'd13},
    '{OP_BYTE,  8'h12, F, F, F, F, 8'h00, F, T, 4'd13},  // R13
    '{OP_STOP,  8'h00, F, F, F, F, 8'h00, F, T, 4'd13},
    // sleep entry: R9
    '{OP_START, 8'h00, F, F, F, F, 8'h00, F, T, 4'd9},
    '{OP_BYTE,  8'hF8, T, T, F, F, 8'h00, F, T, 4'd9},
    '{OP_BYTE,  8'hA2, T, T, F, F, 8'h00, F, T, 4'd9},
    '{OP_START, 8'h00, F, F, F, F, 8'h00, F, T, 4'd9},
    '{OP_BYTE,  8'h86, T, T, F, F, 8'h00, F, T, 4'd9},   // R9 acked, still awake
    '{OP_STOP,  8'h00, F, F, F, F, 8'h00, T, F, 4'd9},   // R9 asleep
    // wake-up: R11
    '{OP_START, 8'h00, F, F, F, F, 8'h00, T, F, 4'd11},
    '{OP_BYTE,  8'hF8, F, F, F, F, 8'h00, T, F, 4'd11},
    '{OP_STOP,  8'h00, F, F, F, F, 8'h00, T, F, 4'd11},
    '{OP_START, 8'h00, F, F, F, F, 8'h00, T, F, 4'd11},
    '{OP_BYTE,  8'hB0, F, F, F, F, 8'h00, T, F, 4'd11},  // R11 other address
    '{OP_STOP,  8'h00, F, F, F, F, 8'h00, T, F, 4'd11},
    '{OP_START, 8'h00, F, F, F, F, 8'h00, T, F, 4'd11},
    '{OP_BYTE,  8'hA1, T, F, F, F, 8'h00, F, F, 4'd11},  // R11 own address
    '{OP_STOP,  8'h00, F, F, F, F, 8'h00, F, F, 4'd12},
    '{OP_START, 8'h00, F, F, F, F, 8'h00, F, F, 4'd12},
    '{OP_BYTE,  8'hA3, T, F, F, F, 8'h00, F, F, 4'd12},  // R12 still waking
    '{OP_STOP,  8'h00, F, F, F, F, 8'h00, F, F, 4'd12}
  };

  logic        clk, rst_n;
  logic [5:0]  own_id;
  logic [63:0] serial_num;
  logic        ev_start, ev_stop, ev_byte, ev_mack, mack_nack;
  logic [7:0]  rx_byte;
  logic        resp_valid, resp_ack, tx_active, asleep, ready;
  logic [7:0]  tx_byte;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  rsv_id_sleep #(.WAKE_CYCLES(WAKE)) u_rsv_id_sleep (
    .clk          (clk),
    .rst_n        (rst_n),
    .own_id_i     (own_id),
    .serial_num_i (serial_num),
    .ev_start_i   (ev_start),
    .ev_stop_i    (ev_stop),
    .ev_byte_i    (ev_byte),
    .rx_byte_i    (rx_byte),
    .ev_mack_i    (ev_mack),
    .mack_nack_i  (mack_nack),
    .resp_valid_o (resp_valid),
    .resp_ack_o   (resp_ack),
    .tx_active_o  (tx_active),
    .tx_byte_o    (tx_byte),
    .asleep_o     (asleep),
    .ready_o      (ready)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic step(input op_e op, input logic [7:0] d);
    @(negedge clk);
    ev_start  = (op == OP_START);
    ev_stop   = (op == OP_STOP);
    ev_byte   = (op == OP_BYTE);
    ev_mack   = (op == OP_ACK) || (op == OP_NACK);
    mack_nack = (op == OP_NACK);
    rx_byte   = d;
    @(negedge clk);
    ev_start = 1'b0; ev_stop = 1'b0; ev_byte = 1'b0;
    ev_mack  = 1'b0; mack_nack = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    own_id     = 6'b101000;
    serial_num = 64'h0000_A1B2C3D4E5_7E;
    ev_start = 1'b0; ev_stop = 1'b0; ev_byte = 1'b0;
    ev_mack = 1'b0; mack_nack = 1'b0; rx_byte = 8'h00;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1", "ready",      {7'd0, ready},      8'd1);
    check("R1", "asleep",     {7'd0, asleep},     8'd0);
    check("R1", "resp_valid", {7'd0, resp_valid}, 8'd0);
    check("R1", "tx_active",  {7'd0, tx_active},  8'd0);

    for (int i = 0; i < NV; i++) begin
      string rq;
      step(VECS[i].op, VECS[i].data);
      rq = $sformatf("R%0d", VECS[i].req);
      check(rq, "resp_valid", {7'd0, resp_valid}, {7'd0, VECS[i].rv});
      if (VECS[i].rv) check(rq, "resp_ack", {7'd0, resp_ack}, {7'd0, VECS[i].ra});
      check(rq, "tx_active", {7'd0, tx_active}, {7'd0, VECS[i].act});
      if (VECS[i].chk_tx) check(rq, "tx_byte", tx_byte, VECS[i].tx);
      check(rq, "asleep", {7'd0, asleep}, {7'd0, VECS[i].slp});
      check(rq, "ready",  {7'd0, ready},  {7'd0, VECS[i].rdy});
    end

    repeat (3 * WAKE) @(negedge clk);
    check("R12", "ready after wake", {7'd0, ready}, 8'd1);

    // R12 exact wake window with a second address mid-window
    step(OP_START, 8'h00); step(OP_BYTE, 8'hF8); step(OP_BYTE, 8'hA0);
    step(OP_START, 8'h00); step(OP_BYTE, 8'h86); step(OP_STOP, 8'h00);
    check("R9", "asleep", {7'd0, asleep}, 8'd1);
    step(OP_START, 8'h00);
    step(OP_BYTE, 8'hA2);              // wake begins at this edge
    check("R11", "wake nack", {6'd0, resp_valid, resp_ack}, 8'b10);
    step(OP_START, 8'h00);
    step(OP_BYTE, 8'hA0);
    check("R12", "nack during wake", {6'd0, resp_valid, resp_ack}, 8'b10);
    repeat (WAKE - 5) @(negedge clk);
    check("R12", "not ready yet", {7'd0, ready}, 8'd0);
    @(negedge clk);
    check("R12", "ready on time", {7'd0, ready}, 8'd1);

    // after wake, a fresh ID read works again
    step(OP_START, 8'h00); step(OP_BYTE, 8'hF8); step(OP_BYTE, 8'hA0);
    step(OP_START, 8'h00); step(OP_BYTE, 8'hF9);
    check("R5", "first id byte after wake", tx_byte, 8'h00);
    step(OP_ACK, 8'h00);
    check("R5", "second id byte after wake", tx_byte, 8'h44);
    step(OP_NACK, 8'h00); step(OP_STOP, 8'h00);

    finish_run();
  end

endmodule